// File: doc/BRIEF.md
# Split-Immediate Single-Precision Register Loader

This block assembles a 32-bit single-precision bit pattern in a 64-bit floating-point register from two 16-bit immediates, which arrive in two separate instructions. The "high" instruction takes its immediate as the upper half of a single-precision word, sets the lower half to zero, converts the word to double precision and writes the register. The "low" instruction reads the register back and converts it down to single precision. It replaces the low 16 bits of that word with its immediate, converts the result up to double precision again and writes the register.

The block holds a small register file, the decoder for the two instructions, a program counter and the two format converters. It accepts one instruction per cycle. Each write lands on the next clock edge. A combinational read port lets the environment observe any register.

Top module: `fpimm_loader`

## Requirements
- R1: While `rstN` is low, and on the first edge after it rises, every register reads 0 and `pc` reads 0.
- R2: A valid instruction with `instOp`=0 (high half) writes register `instReg` with the double-precision form of the single-precision pattern {`instImm`, 16'h0000}.
- R3: A valid instruction with `instOp`=1 (low half) converts register `instReg` to single precision, keeps bits [31:16] of the result, puts `instImm` in bits [15:0] and writes back the double-precision form. The pairs 4049/0FD0, C049/0FD0, 3F80/4000 and 89AB/CDEF give 0x400921FA00000000, 0xC00921FA00000000, 0x3FF0080000000000 and 0xB93579BDE0000000.
- R4: Widening a single-precision normal number keeps the sign (bit 31 to bit 63) and adds 896 to the 8-bit exponent to form the 11-bit exponent. The 23 fraction bits go to bits [51:29], and bits [28:0] are zero.
- R5: Widening a single-precision zero gives a signed double-precision zero. An all-ones single-precision exponent gives exponent 0x7FF with the fraction placed as in R4.
- R6: Widening a single-precision denormal gives a normal double-precision value. The leading one is dropped, the remaining fraction bits are left-aligned in bits [51:29], and the exponent is 874 plus the bit position of the leading one.
- R7: Narrowing truncates and restores the original pattern for any value produced by widening. Exponents from 897 to 1150 lose 896. Exponents below 897 become a denormal formed by shifting {1, fraction} right by 897 minus the exponent. Exponent 0x7FF becomes 0xFF and keeps the top 23 fraction bits.
- R8: `pc` advances by 4 for each cycle with `instValid` high and holds otherwise.
- R9: A cycle with `instValid` low changes no register.
- R10: `rdData` shows register `rdIdx` combinationally. In the cycle of a write to that register it still shows the old value, and it shows the new value after the edge.
- R11: An instruction changes only register `instReg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| instValid | input | 1 | Instruction present this cycle |
| instOp | input | 1 | 0 = high-half load, 1 = low-half patch |
| instReg | input | 5 | Target register index |
| instImm | input | 16 | Immediate half-word |
| rdIdx | input | 5 | Read port register index |
| rdData | output | 64 | Read port data |
| pc | output | 32 | Program counter |

## Verification
A register can be written and observed through the read port in the same cycle. It can also be patched by a low-half instruction in the cycle right after a high-half write to it. The bench provokes the first case by holding `rdIdx` on the target during a write. It judges the result by sampling old data before the edge and new data after it. It provokes the second case with back-to-back high/low pairs, both directed and random, and compares each result with a bench model of both conversions built from R4 to R7.

// File: rtl/fpimm_loader_pkg.sv
package fpimm_loader_pkg;
  localparam int SpExpW  = 8;
  localparam int SpManW  = 23;
  localparam int DpExpW  = 11;
  localparam int DpManW  = 52;
  localparam int SpW     = 1 + SpExpW + SpManW;
  localparam int DpW     = 1 + DpExpW + DpManW;
  localparam int SpBias  = (1 << (SpExpW - 1)) - 1;
  localparam int DpBias  = (1 << (DpExpW - 1)) - 1;
  localparam int BiasGap = DpBias - SpBias;
  localparam int ManPad  = DpManW - SpManW;
  localparam int HalfW   = SpW / 2;

  typedef enum logic {
    OP_HIGH = 1'b0,
    OP_LOW  = 1'b1
  } op_e;

  typedef struct packed {
    logic wrEn;
    logic takeLow;
    logic pcStep;
  } strobe_t;
endpackage

// File: rtl/fhl_widen.sv
module fhl_widen
  import fpimm_loader_pkg::*;
(
  input  logic [SpW-1:0] spIn,
  output logic [DpW-1:0] dpOut
);
  localparam int LeadW = $clog2(SpManW + 1);
  localparam logic [DpExpW-1:0] DenBase = DpExpW'(BiasGap - SpManW + 1);

  logic                sgn;
  logic [SpExpW-1:0]   exp8;
  logic [SpManW-1:0]   man;
  logic [LeadW-1:0]    lead;
  logic [SpManW:0]     normSig;
  logic [DpExpW-1:0]   denExp;

  assign sgn  = spIn[SpW-1];
  assign exp8 = spIn[SpW-2:SpManW];
  assign man  = spIn[SpManW-1:0];

  always_comb begin
    lead = '0;
    for (int i = 0; i < SpManW; i++) begin
      if (man[i]) lead = LeadW'(i);
    end
  end

  assign normSig = {1'b0, man} << (LeadW'(SpManW) - lead);
  assign denExp  = DenBase + DpExpW'(lead);

  always_comb begin
    if (exp8 == '0 && man == '0) begin
      dpOut = {sgn, {(DpW-1){1'b0}}};
    end else if (exp8 == '1) begin
      dpOut = {sgn, {DpExpW{1'b1}}, man, {ManPad{1'b0}}};
    end else if (exp8 == '0) begin
      dpOut = {sgn, denExp, normSig[SpManW-1:0], {ManPad{1'b0}}};
    end else begin
      dpOut = {sgn, DpExpW'(exp8) + DpExpW'(BiasGap), man, {ManPad{1'b0}}};
    end
  end
endmodule

// File: rtl/fhl_narrow.sv
module fhl_narrow
  import fpimm_loader_pkg::*;
(
  input  logic [DpW-1:0] dpIn,
  output logic [SpW-1:0] spOut
);
  localparam logic [DpExpW-1:0] MinNorm = DpExpW'(BiasGap + 1);
  localparam logic [DpExpW-1:0] MaxNorm = DpExpW'(BiasGap + (1 << SpExpW) - 2);

  logic                sgn;
  logic [DpExpW-1:0]   exp11;
  logic [SpManW-1:0]   topMan;
  logic [DpExpW-1:0]   shiftAmt;
  logic [SpManW:0]     denSig;

  assign sgn    = dpIn[DpW-1];
  assign exp11  = dpIn[DpW-2:DpManW];
  assign topMan = dpIn[DpManW-1:ManPad];
  assign shiftAmt = MinNorm - exp11;

  always_comb begin
    if (shiftAmt > DpExpW'(SpManW + 1)) denSig = '0;
    else denSig = {1'b1, topMan} >> shiftAmt;
  end

  always_comb begin
    if (exp11 == '0) begin
      spOut = {sgn, {(SpW-1){1'b0}}};
    end else if (exp11 == '1) begin
      spOut = {sgn, {SpExpW{1'b1}}, topMan};
    end else if (exp11 > MaxNorm) begin
      spOut = {sgn, {SpExpW{1'b1}}, {SpManW{1'b0}}};
    end else if (exp11 >= MinNorm) begin
      spOut = {sgn, SpExpW'(exp11 - DpExpW'(BiasGap)), topMan};
    end else begin
      spOut = {sgn, {SpExpW{1'b0}}, denSig[SpManW-1:0]};
    end
  end
endmodule

// File: rtl/fhl_ctrl.sv
module fhl_ctrl
  import fpimm_loader_pkg::*;
(
  input  logic    instValid,
  input  logic    instOp,
  output strobe_t strobes
);
  always_comb begin
    strobes.wrEn    = instValid;
    strobes.pcStep  = instValid;
    strobes.takeLow = instValid && (op_e'(instOp) == OP_LOW);
  end
endmodule

// File: rtl/fhl_dpath.sv
module fhl_dpath
  import fpimm_loader_pkg::*;
#(
  parameter int NumRegs = 32,
  parameter int PcW     = 32,
  parameter int PcStep  = 4,
  localparam int IdxW   = $clog2(NumRegs)
)(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [IdxW-1:0]  instReg,
  input  logic [HalfW-1:0] instImm,
  input  logic [IdxW-1:0]  rdIdx,
  output logic [DpW-1:0]   rdData,
  output logic [PcW-1:0]   pc
);
  logic [DpW-1:0] regs [NumRegs];
  logic [DpW-1:0] srcVal;
  logic [SpW-1:0] srcSp;
  logic [SpW-1:0] newSp;
  logic [DpW-1:0] newDp;

  assign srcVal = regs[instReg];

  fhl_narrow uNarrow (.dpIn(srcVal), .spOut(srcSp));

  assign newSp = strobes.takeLow ? {srcSp[SpW-1:HalfW], instImm}
                                 : {instImm, {HalfW{1'b0}}};

  fhl_widen uWiden (.spIn(newSp), .dpOut(newDp));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NumRegs; i++) regs[i] <= '0;
      pc <= '0;
    end else begin
      if (strobes.wrEn) regs[instReg] <= newDp;
      if (strobes.pcStep) pc <= pc + PcW'(PcStep);
    end
  end

  assign rdData = regs[rdIdx];
endmodule

// File: rtl/fpimm_loader.sv
module fpimm_loader
  import fpimm_loader_pkg::*;
#(
  parameter int NumRegs = 32,
  parameter int PcW     = 32,
  localparam int IdxW   = $clog2(NumRegs)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic             instOp,
  input  logic [IdxW-1:0]  instReg,
  input  logic [HalfW-1:0] instImm,
  input  logic [IdxW-1:0]  rdIdx,
  output logic [DpW-1:0]   rdData,
  output logic [PcW-1:0]   pc
);
  strobe_t strobes;

  fhl_ctrl uCtrl (
    .instValid(instValid),
    .instOp(instOp),
    .strobes(strobes)
  );

  fhl_dpath #(.NumRegs(NumRegs), .PcW(PcW)) uDpath (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .instReg(instReg),
    .instImm(instImm),
    .rdIdx(rdIdx),
    .rdData(rdData),
    .pc(pc)
  );
endmodule

// File: rtl/fpimm_loader_chk.sv
module fpimm_loader_chk #(
  parameter int IdxW = 5,
  parameter int PcW  = 32
)(
  input logic            clk,
  input logic            rstN,
  input logic            instValid,
  input logic            instOp,
  input logic [IdxW-1:0] instReg,
  input logic [15:0]     instImm,
  input logic [IdxW-1:0] rdIdx,
  input logic [63:0]     rdData,
  input logic [PcW-1:0]  pc
);
  logic pastOk;
  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else pastOk <= 1'b1;
  end

  // R1
  reset_pc_chk: assert property (@(posedge clk) !rstN |=> pc == '0);

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(instValid)) |-> pc == $past(pc) + PcW'(4));

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(instValid)) |-> pc == $past(pc));

  // R9
  no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && rdIdx == $past(rdIdx) &&
     (!$past(instValid) || $past(instReg) != rdIdx)) |-> rdData == $past(rdData));

  // R2
  high_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(instValid) && !$past(instOp) && rdIdx == $past(instReg))
      |-> rdData[63] == $past(instImm[15]));

  // R4
  low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(instValid) && rdIdx == $past(instReg)) |-> rdData[28:0] == '0);
endmodule

bind fpimm_loader fpimm_loader_chk #(.IdxW(IdxW), .PcW(PcW)) uChk (
  .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
  .instReg(instReg), .instImm(instImm), .rdIdx(rdIdx), .rdData(rdData), .pc(pc)
);

// File: tb/fpimm_loader_test.sv
module fpimm_loader_test;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic        instOp = 1'b0;
  logic [4:0]  instReg = '0;
  logic [15:0] instImm = '0;
  logic [4:0]  rdIdx = '0;
  logic [63:0] rdData;
  logic [31:0] pc;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;
  logic [63:0] mdl [32];
  logic [31:0] mdlPc = '0;

  always #(ClkPeriod/2) clk = ~clk;

  fpimm_loader uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instReg(instReg), .instImm(instImm), .rdIdx(rdIdx), .rdData(rdData), .pc(pc)
  );

  function automatic logic [63:0] toDouble(input logic [31:0] s);
    logic [23:0] sig;
    int ex;
    sig = {1'b0, s[22:0]};
    if (s[30:23] == 8'hFF) return {s[31], 11'h7FF, s[22:0], 29'b0};
    if (s[30:0] == 31'b0) return {s[31], 63'b0};
    if (s[30:23] != 8'h00) return {s[31], 11'(int'(s[30:23]) - 127 + 1023), s[22:0], 29'b0};
    ex = 1023 - 126;
    while (!sig[23]) begin
      sig = sig << 1;
      ex = ex - 1;
    end
    return {s[31], 11'(ex), sig[22:0], 29'b0};
  endfunction

  function automatic logic [31:0] toSingle(input logic [63:0] d);
    int ex;
    logic [23:0] sig;
    ex = int'(d[62:52]);
    if (ex == 0) return {d[63], 31'b0};
    if (ex == 2047) return {d[63], 8'hFF, d[51:29]};
    if (ex - 1023 > 127) return {d[63], 8'hFF, 23'b0};
    if (ex - 1023 >= -126) return {d[63], 8'(ex - 1023 + 127), d[51:29]};
    sig = {1'b1, d[51:29]};
    for (int k = ex; k < 897; k++) sig = sig >> 1;
    return {d[63], 8'h00, sig[22:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input int r, output logic [63:0] v);
    rdIdx = 5'(r);
    #1;
    v = rdData;
  endtask

  task automatic issue(input bit valid, input bit op, input int r, input logic [15:0] imm);
    @(negedge clk);
    instValid = valid; instOp = op; instReg = 5'(r); instImm = imm;
    if (valid) begin
      mdlPc = mdlPc + 4;
      if (!op) mdl[r] = toDouble({imm, 16'h0});
      else mdl[r] = toDouble({toSingle(mdl[r])[31:16], imm});
    end
    @(posedge clk);
    #2;
    instValid = 1'b0;
  endtask

  task automatic pairCheck(input int r, input logic [15:0] hi, input logic [15:0] lo,
                           input logic [63:0] exp, input string tag);
    logic [63:0] v;
    issue(1, 0, r, hi);
    issue(1, 1, r, lo);
    readReg(r, v);
    check(tag, v, exp);
  endtask

  initial begin
    #(ClkPeriod * 100000);
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] oldV;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 pc", 64'(pc), 64'h0);
    readReg(0, v); check("R1 reg0", v, 64'h0);
    readReg(31, v); check("R1 reg31", v, 64'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R3 directed pairs
    pairCheck(3, 16'h4049, 16'h0FD0, 64'h400921FA00000000, "R3 pi");
    pairCheck(4, 16'h3F80, 16'h4000, 64'h3FF0080000000000, "R3 one");
    pairCheck(5, 16'hC049, 16'h0FD0, 64'hC00921FA00000000, "R3 negpi");
    pairCheck(6, 16'h89AB, 16'hCDEF, 64'hB93579BDE0000000, "R3 bits");
    #1;
    check("R8 pc after eight", 64'(pc), 64'h20);

    // R2 high half alone, R4 normal widening
    issue(1, 0, 7, 16'h4049);
    readReg(7, v); check("R2 R4 high only", v, 64'h4009200000000000);

    // R5 zero and special exponents
    pairCheck(8, 16'h0000, 16'h0000, 64'h0, "R5 pos zero");
    issue(1, 0, 9, 16'h8000);
    readReg(9, v); check("R5 neg zero", v, 64'h8000000000000000);
    issue(1, 0, 10, 16'h7F80);
    readReg(10, v); check("R5 inf", v, 64'h7FF0000000000000);
    issue(1, 0, 11, 16'hFFC0);
    readReg(11, v); check("R5 nan", v, 64'hFFF8000000000000);

    // R6 denormal widening, R7 denormal narrowing round trip
    pairCheck(12, 16'h0000, 16'h0001, 64'h36A0000000000000, "R6 min denorm");
    issue(1, 1, 12, 16'h0003);
    readReg(12, v); check("R7 denorm patch", v, 64'h36B8000000000000);
    pairCheck(13, 16'h0040, 16'h0000, 64'h3800000000000000, "R6 top denorm");

    // R9 invalid cycle leaves register and pc
    readReg(3, oldV);
    issue(0, 1, 3, 16'hFFFF);
    readReg(3, v); check("R9 no write", v, oldV);
    check("R8 pc hold", 64'(pc), 64'(mdlPc));

    // R10 same-cycle read of written register
    @(negedge clk);
    rdIdx = 5'd4; instValid = 1'b1; instOp = 1'b0; instReg = 5'd4; instImm = 16'h4000;
    mdl[4] = toDouble(32'h40000000); mdlPc = mdlPc + 4;
    #1;
    check("R10 old before edge", rdData, 64'h3FF0080000000000);
    @(posedge clk);
    #2;
    instValid = 1'b0;
    check("R10 new after edge", rdData, 64'h4000000000000000);

    // R11 neighbours untouched
    readReg(5, v); check("R11 neighbour", v, 64'hC00921FA00000000);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      int other;
      bit vld;
      bit op;
      logic [15:0] imm;
      r = int'($urandom % 32);
      other = int'($urandom % 32);
      vld = ($urandom % 8) != 0;
      op = $urandom % 2;
      imm = 16'($urandom);
      if (n % 16 == 0) imm = 16'h0000;
      issue(vld, op, r, imm);
      readReg(r, v);
      check(vld ? (op ? "R3 random" : "R2 random") : "R9 random", v, mdl[r]);
      readReg(other, v);
      check("R11 random other", v, mdl[other]);
    end
    #1;
    check("R8 pc final", 64'(pc), 64'(mdlPc));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule